// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every beat of a read or write burst for a synchronous DRAM whose rows hold 2^COL_W columns (512 with the default 9-bit column). A column command presents a starting column, a burst-length code and an ordering choice. From the clock edge that accepts the command, the block issues one column address per cycle with a valid flag, and it flags the final beat.

Two orderings are offered. Sequential ordering counts upward and wraps inside the aligned block the burst length defines. Interleaved ordering XORs the beat number into the low start bits. A full-page length runs sequentially across the whole row, wraps from the top column to column 0, and continues until it is stopped. A stop command ends a burst at once. A new column command, accepted on any cycle, replaces the burst in progress.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After a synchronous reset, col_valid and col_last are 0 and col_addr is 0.
- R2: When cmd_start is high at a clock edge, that edge drives col_valid to 1 and col_addr to start_col. This is beat 0.
- R3: The length codes are 3'b000 for 1, 3'b001 for 2, 3'b010 for 4, 3'b011 for 8 and 3'b111 for full page. col_valid stays high for exactly that many beats, and col_last is high only on the final beat.
- R4: With interleave low, beat n keeps the column bits above the low log2(L) bits and sets the low bits to (start low bits + n) mod L. For example, L=4 from column 6 gives 6,7,4,5.
- R5: With interleave high and L of 8 or less, beat n sets the low log2(L) bits to the start low bits XOR n. For example, L=8 from column 5 gives 5,4,7,6,1,0,3,2.
- R6: A full-page burst steps by one modulo 2^COL_W, so 511 is followed by 0. It never raises col_last and runs until it is stopped or replaced.
- R7: The full-page code ignores interleave and always orders sequentially. The reserved codes 3'b100 to 3'b110 behave as length 1.
- R8: A length-1 burst raises col_last on beat 0, and col_valid falls on the next edge.
- R9: burst_stop high at an edge without cmd_start drops col_valid and col_last at that edge. When no burst is running, burst_stop has no effect. When cmd_start and burst_stop arrive together, cmd_start wins.
- R10: A cmd_start during a burst drops the old burst and starts the new one at the same edge. Commands may arrive on every clock.
- R11: Length and ordering are captured with cmd_start. Changes to len_code or interleave during a burst do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Column command (read or write) accepted this cycle |
| start_col | input | COL_W | Starting column of the new burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects sequential |
| burst_stop | input | 1 | End the running burst now |
| col_valid | output | 1 | col_addr carries a beat |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach is the full-page wrap: the row boundary must be crossed and the burst must keep running well past one row length without ever flagging a last beat. The stimulus starts a full-page burst three columns below the top of the row and follows it for more than a full row before stopping it. The same sequence is repeated with interleave requested. Restart and stop are applied mid-burst at chosen beats. Configuration inputs are toggled during a burst to show that they were captured.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

endpackage

// File: rtl/colgen_cfg_decode.sv
module colgen_cfg_decode
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       len_code,
  input  logic             ilv_req,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page_mode,
  output logic             ilv_eff
);

  always_comb begin
    wrap_mask = '0;
    page_mode = 1'b0;
    ilv_eff   = ilv_req;
    case (len_code)
      LEN_2:    wrap_mask = COL_W'(1);
      LEN_4:    wrap_mask = COL_W'(3);
      LEN_8:    wrap_mask = COL_W'(7);
      LEN_PAGE: begin
        wrap_mask = '1;
        page_mode = 1'b1;
        ilv_eff   = 1'b0;
      end
      default:  wrap_mask = '0;
    endcase
  end

endmodule

// File: rtl/colgen_addr_order.sv
module colgen_addr_order #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_num,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] beat_col
);

  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] xor_low;

  assign seq_low = base_col + beat_num;
  assign xor_low = base_col ^ beat_num;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!wrap_mask[b])
        beat_col[b] = base_col[b];
      else if (ilv)
        beat_col[b] = xor_low[b];
      else
        beat_col[b] = seq_low[b];
    end
  end

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             burst_stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_ilv;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] beat_q;
  logic             page_q;
  logic             ilv_q;

  logic [COL_W-1:0] nxt_beat;
  logic [COL_W-1:0] nxt_col;

  colgen_cfg_decode #(.COL_W(COL_W)) u_decode (
    .len_code  (len_code),
    .ilv_req   (interleave),
    .wrap_mask (dec_mask),
    .page_mode (dec_page),
    .ilv_eff   (dec_ilv)
  );

  assign nxt_beat = beat_q + COL_W'(1);

  colgen_addr_order #(.COL_W(COL_W)) u_order (
    .base_col  (base_q),
    .beat_num  (nxt_beat),
    .wrap_mask (mask_q),
    .ilv       (ilv_q),
    .beat_col  (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      mask_q    <= '0;
      beat_q    <= '0;
      page_q    <= 1'b0;
      ilv_q     <= 1'b0;
      col_valid <= 1'b0;
      col_addr  <= '0;
      col_last  <= 1'b0;
    end else if (cmd_start) begin
      base_q    <= start_col;
      mask_q    <= dec_mask;
      beat_q    <= '0;
      page_q    <= dec_page;
      ilv_q     <= dec_ilv;
      col_valid <= 1'b1;
      col_addr  <= start_col;
      col_last  <= !dec_page && (dec_mask == '0);
    end else if (burst_stop) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end else if (col_valid && !col_last) begin
      beat_q    <= nxt_beat;
      col_addr  <= nxt_col;
      col_last  <= !page_q && (nxt_beat == mask_q);
    end else begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_col_burst_gen_chk.sv
module sdram_col_burst_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_start,
  input logic [COL_W-1:0] start_col,
  input logic             burst_stop,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last
);

  p_last_in_burst_r3: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  p_start_loads_col_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> (col_valid && col_addr == $past(start_col)));

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (burst_stop && !cmd_start) |=> !col_valid);

  p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (col_last && !cmd_start) |=> !col_valid);

  p_burst_continues_r3: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !cmd_start && !burst_stop) |=> col_valid);

endmodule

bind sdram_col_burst_gen sdram_col_burst_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_start  (cmd_start),
  .start_col  (start_col),
  .burst_stop (burst_stop),
  .col_valid  (col_valid),
  .col_addr   (col_addr),
  .col_last   (col_last)
);

// File: tb/test_sdram_col_burst_gen.sv
`timescale 1ns/1ps
module test_sdram_col_burst_gen;

  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmd_start;
  logic [COL_W-1:0] start_col;
  logic [2:0]       len_code;
  logic             interleave;
  logic             burst_stop;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sdram_col_burst_gen #(.COL_W(COL_W)) i_sdram_col_burst_gen (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .burst_stop(burst_stop),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // beat: expect valid, address and last
  task automatic beat(input string req, input int a, input int l);
    chk({req, " valid"}, int'(col_valid), 1);
    chk({req, " addr"},  int'(col_addr), a);
    chk({req, " last"},  int'(col_last), l);
  endtask

  task automatic idle(input string req);
    chk({req, " idle valid"}, int'(col_valid), 0);
    chk({req, " idle last"},  int'(col_last), 0);
  endtask

  // issue a command; returns at the negedge after the accepting edge
  task automatic issue(input int col, input logic [2:0] code, input logic ilv);
    @(negedge clk);
    cmd_start  = 1'b1;
    start_col  = COL_W'(col);
    len_code   = code;
    interleave = ilv;
    @(negedge clk);
    cmd_start  = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; cmd_start = 0; start_col = '0; len_code = 0;
    interleave = 0; burst_stop = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid", int'(col_valid), 0);
    chk("R1 last",  int'(col_last), 0);
    chk("R1 addr",  int'(col_addr), 0);
  endtask

  task automatic t_seq4;
    int exp[4] = '{6, 7, 4, 5};
    issue(6, 3'b010, 0);
    for (int n = 0; n < 4; n++) begin
      beat("R4 R2", exp[n], n == 3);
      @(negedge clk);
    end
    idle("R3");
  endtask

  task automatic t_seq2;
    issue(3, 3'b001, 0);
    beat("R3 len2", 3, 0);
    @(negedge clk); beat("R4 len2", 2, 1);
    @(negedge clk); idle("R3 len2");
  endtask

  task automatic t_ilv8;
    int exp[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
    issue(5, 3'b011, 1);
    for (int n = 0; n < 8; n++) begin
      beat("R5", exp[n], n == 7);
      @(negedge clk);
    end
    idle("R5");
  endtask

  task automatic t_len1;
    issue(77, 3'b000, 1);
    beat("R8", 77, 1);
    @(negedge clk); idle("R8");
    issue(130, 3'b101, 0);
    beat("R7 reserved", 130, 1);
    @(negedge clk); idle("R7 reserved");
  endtask

  task automatic t_page(input logic ilv, input string req);
    issue(509, 3'b111, ilv);
    for (int n = 0; n < 600; n++) begin
      beat(req, (509 + n) % 512, 0);
      if (n == 599) burst_stop = 1'b1;
      @(negedge clk);
    end
    burst_stop = 1'b0;
    idle({req, " R9 stop"});
  endtask

  task automatic t_stop;
    issue(0, 3'b011, 0);
    beat("R9", 0, 0);
    @(negedge clk); beat("R9", 1, 0);
    burst_stop = 1'b1;
    @(negedge clk); idle("R9 mid");
    @(negedge clk); idle("R9 idle stop");
    burst_stop = 1'b0;
    @(negedge clk); idle("R9 after");
    // start and stop together: start wins
    @(negedge clk);
    cmd_start = 1; burst_stop = 1; start_col = 9'd200; len_code = 3'b001; interleave = 0;
    @(negedge clk);
    cmd_start = 0; burst_stop = 0;
    beat("R9 start wins", 200, 0);
    @(negedge clk); beat("R9 start wins", 201, 1);
    @(negedge clk); idle("R9");
  endtask

  task automatic t_restart;
    issue(16, 3'b011, 0);
    beat("R10", 16, 0);
    @(negedge clk); beat("R10", 17, 0);
    issue(40, 3'b001, 0);
    beat("R10 new", 40, 0);
    @(negedge clk); beat("R10 new", 41, 1);
    @(negedge clk); idle("R10");
    // commands every clock
    @(negedge clk);
    cmd_start = 1; len_code = 3'b000; interleave = 0; start_col = 9'd10;
    @(negedge clk); beat("R10 b2b", 10, 1); start_col = 9'd20;
    @(negedge clk); beat("R10 b2b", 20, 1); start_col = 9'd30;
    @(negedge clk); beat("R10 b2b", 30, 1); cmd_start = 0;
    @(negedge clk); idle("R10 b2b");
  endtask

  task automatic t_capture;
    issue(8, 3'b010, 0);
    len_code = 3'b111; interleave = 1'b1;
    for (int n = 0; n < 4; n++) begin
      beat("R11", 8 + n, n == 3);
      @(negedge clk);
    end
    idle("R11");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_seq4();
    t_seq2();
    t_ilv8();
    t_len1();
    t_page(1'b0, "R6");
    t_page(1'b1, "R7 page ilv");
    t_stop();
    t_restart();
    t_capture();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule